// File: doc/BRIEF.md
# Wheel-Speed Input Channel Power-Up Self-Test

This block proves that a wheel-speed digital input path is intact before any real sensor pulses reach the control processor. While reset is asserted and for the whole test, the block holds its channel-enable line low. That line drives an external analog switch, so keeping it low cuts the real sensor off from the channel. During this time the block injects a square wave of known frequency into the channel. The host at the far end counts the pulses that come back over a fixed measurement window and reports the result.

The test tone has a 50% duty cycle. It runs for exactly one window holding a fixed number of pulses. The block then waits a bounded time for the host's verdict. If the host confirms a match, the channel-enable line goes high and the raw wheel-speed pulse is forwarded. If the host reports a mismatch, or gives no verdict in time, the block latches a fault, keeps the channel shielded and blocks every wheel pulse until the next reset. The tone frequency, the pulses per window and the timeout length are all parameters, derived from a generic clock frequency.

Top module: `chan_selftest`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `chan_enable`, `fault`, `stim_out` and `wheel_fwd` are all low.
- R2: During the test phase, `stim_out` is a square wave with a period of 2·H clock cycles, where H = CLK_HZ/(2·TONE_HZ). It is low for H cycles and then high for H cycles, starting low.
- R3: The test phase lasts exactly WINDOW_PULSES·2·H cycles and contains exactly WINDOW_PULSES rising edges on `stim_out`. After it, `stim_out` stays low.
- R4: `test_done` and `test_pass` have no effect during the test phase. The channel stays shielded and the block still waits for a verdict after the window ends.
- R5: If `test_done` and `test_pass` are both high in a waiting cycle, `chan_enable` goes high on the next cycle and `wheel_fwd` then follows `wheel_in`.
- R6: If `test_done` is high with `test_pass` low in a waiting cycle, `fault` goes high on the next cycle and `chan_enable` stays low.
- R7: If no `test_done` arrives within TIMEOUT_WINDOWS windows (TIMEOUT_WINDOWS·WINDOW_PULSES·2·H waiting cycles), `fault` goes high on the cycle after the last waiting cycle. A verdict that arrives in that last waiting cycle takes priority over the timeout.
- R8: `wheel_fwd` is low whenever `chan_enable` is low, whatever `wheel_in` does.
- R9: Once `chan_enable` or `fault` is high, it stays high until reset, and further handshake inputs are ignored.
- R10: `fault` and `chan_enable` are never high together, and `stim_out` is low while either one is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| test_done | input | 1 | Host strobe: verdict is valid |
| test_pass | input | 1 | Host verdict: 1 = measured frequency matched |
| wheel_in | input | 1 | Raw wheel-speed pulse from the sensor path |
| chan_enable | output | 1 | High closes the analog switch; low shields the channel |
| stim_out | output | 1 | Injected test square wave |
| wheel_fwd | output | 1 | Wheel-speed pulse forwarded to the processor |
| fault | output | 1 | Latched channel fault |

## Verification
The assertions check on every cycle that fault and enable exclude each other, that both are sticky, that the forwarded pulse is blocked while shielded and tracks the input while enabled, that the tone is silent outside the test, and that enable only rises after a passing verdict. Only the bench scenarios can show the cycle-exact tone shape, the count of pulses in the window, that handshakes are ignored during the test, the exact length of the timeout, and that a verdict wins over a simultaneous timeout.

// File: rtl/chan_selftest_pkg.sv
package chan_selftest_pkg;

    typedef enum logic [2:0] {
        ST_RESET  = 3'd0,
        ST_SHIELD = 3'd1,
        ST_WAIT   = 3'd2,
        ST_RUN    = 3'd3,
        ST_FAULT  = 3'd4
    } chan_state_e;

    typedef struct packed {
        logic enable;
        logic fault;
        logic tone_en;
        logic wait_en;
    } chan_ctrl_t;

    function automatic int half_period(input int clk_hz, input int tone_hz);
        return clk_hz / (2 * tone_hz);
    endfunction

    function automatic int window_cycles(input int clk_hz, input int tone_hz, input int pulses);
        return 2 * half_period(clk_hz, tone_hz) * pulses;
    endfunction

endpackage

// File: rtl/chan_tone_gen.sv
module chan_tone_gen #(
    parameter int HALF   = 10,
    parameter int PULSES = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    output logic stim,
    output logic window_done
);
    localparam int CW = $clog2(HALF + 1);
    localparam int PW = $clog2(PULSES + 1);
    localparam logic [CW-1:0] HALF_LAST = CW'(HALF - 1);
    localparam logic [PW-1:0] PER_LAST  = PW'(PULSES - 1);

    logic [CW-1:0] cnt;
    logic [PW-1:0] periods;
    logic          phase;

    assign window_done = en && (cnt == HALF_LAST) && phase && (periods == PER_LAST);
    assign stim        = phase;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt     <= '0;
            periods <= '0;
            phase   <= 1'b0;
        end else if (cnt == HALF_LAST) begin
            cnt   <= '0;
            phase <= ~phase;
            if (phase) begin
                periods <= window_done ? '0 : periods + 1'b1;
            end
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/chan_timeout_ctr.sv
module chan_timeout_ctr #(
    parameter int LIMIT = 400
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    output logic expired
);
    localparam int TW = $clog2(LIMIT + 1);
    localparam logic [TW-1:0] LAST = TW'(LIMIT - 1);

    logic [TW-1:0] cnt;

    assign expired = en && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt <= '0;
        end else if (!expired) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/chan_test_fsm.sv
module chan_test_fsm
    import chan_selftest_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       window_done,
    input  logic       expired,
    input  logic       test_done,
    input  logic       test_pass,
    output chan_ctrl_t ctrl
);
    chan_state_e state, state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_RESET:  state_nx = ST_SHIELD;
            ST_SHIELD: if (window_done) state_nx = ST_WAIT;
            ST_WAIT: begin
                if (test_done)    state_nx = test_pass ? ST_RUN : ST_FAULT;
                else if (expired) state_nx = ST_FAULT;
            end
            ST_RUN:    state_nx = ST_RUN;
            ST_FAULT:  state_nx = ST_FAULT;
            default:   state_nx = ST_FAULT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_RESET;
        else     state <= state_nx;
    end

    always_comb begin
        ctrl.enable  = (state == ST_RUN);
        ctrl.fault   = (state == ST_FAULT);
        ctrl.tone_en = (state == ST_SHIELD);
        ctrl.wait_en = (state == ST_WAIT);
    end
endmodule

// File: rtl/chan_selftest.sv
module chan_selftest
    import chan_selftest_pkg::*;
#(
    parameter int CLK_HZ          = 50_000_000,
    parameter int TONE_HZ         = 100,
    parameter int WINDOW_PULSES   = 10,
    parameter int TIMEOUT_WINDOWS = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic test_done,
    input  logic test_pass,
    input  logic wheel_in,
    output logic chan_enable,
    output logic stim_out,
    output logic wheel_fwd,
    output logic fault
);
    localparam int HALF      = half_period(CLK_HZ, TONE_HZ);
    localparam int WIN_CYC   = window_cycles(CLK_HZ, TONE_HZ, WINDOW_PULSES);
    localparam int TO_CYC    = TIMEOUT_WINDOWS * WIN_CYC;

    chan_ctrl_t ctrl;
    logic       tone;
    logic       window_done;
    logic       expired;

    chan_tone_gen #(.HALF(HALF), .PULSES(WINDOW_PULSES)) u_tone (
        .clk(clk), .rst(rst), .en(ctrl.tone_en),
        .stim(tone), .window_done(window_done)
    );

    chan_timeout_ctr #(.LIMIT(TO_CYC)) u_timeout (
        .clk(clk), .rst(rst), .en(ctrl.wait_en), .expired(expired)
    );

    chan_test_fsm u_fsm (
        .clk(clk), .rst(rst), .window_done(window_done), .expired(expired),
        .test_done(test_done), .test_pass(test_pass), .ctrl(ctrl)
    );

    assign chan_enable = ctrl.enable;
    assign fault       = ctrl.fault;
    assign stim_out    = tone & ctrl.tone_en;
    assign wheel_fwd   = wheel_in & ctrl.enable;
endmodule

// File: rtl/chan_selftest_chk.sv
module chan_selftest_chk (
    input logic clk,
    input logic rst,
    input logic test_done,
    input logic test_pass,
    input logic wheel_in,
    input logic chan_enable,
    input logic stim_out,
    input logic wheel_fwd,
    input logic fault
);
    // R10
    excl_chk: assert property (@(posedge clk) disable iff (rst) !(fault && chan_enable));
    // R10
    tone_quiet_chk: assert property (@(posedge clk) disable iff (rst) (fault || chan_enable) |-> !stim_out);
    // R9
    fault_sticky_chk: assert property (@(posedge clk) disable iff (rst) fault |=> fault);
    // R9
    enable_sticky_chk: assert property (@(posedge clk) disable iff (rst) chan_enable |=> chan_enable);
    // R8
    fwd_block_chk: assert property (@(posedge clk) disable iff (rst) !chan_enable |-> !wheel_fwd);
    // R5
    fwd_follow_chk: assert property (@(posedge clk) disable iff (rst) chan_enable |-> (wheel_fwd == wheel_in));
    // R5
    enable_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(chan_enable) |-> $past(test_done && test_pass));
    // R1
    reset_quiet_chk: assert property (@(posedge clk) rst |=> (!chan_enable && !fault));
endmodule

bind chan_selftest chan_selftest_chk u_chk (.*);

// File: tb/tb_chan_selftest.sv
module tb_chan_selftest;
    localparam int CLK_HZ = 2000;
    localparam int TONE   = 100;
    localparam int NP     = 10;
    localparam int TW     = 2;
    localparam int HALF   = CLK_HZ / (2 * TONE);
    localparam int WIN    = 2 * HALF * NP;
    localparam int TO     = TW * WIN;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic test_done = 1'b0, test_pass = 1'b0, wheel_in = 1'b0;
    logic chan_enable, stim_out, wheel_fwd, fault;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    chan_selftest #(.CLK_HZ(CLK_HZ), .TONE_HZ(TONE), .WINDOW_PULSES(NP),
                    .TIMEOUT_WINDOWS(TW)) dut (
        .clk(clk), .rst(rst), .test_done(test_done), .test_pass(test_pass),
        .wheel_in(wheel_in), .chan_enable(chan_enable), .stim_out(stim_out),
        .wheel_fwd(wheel_fwd), .fault(fault)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; test_done = 1'b0; test_pass = 1'b0;
        repeat (3) @(negedge clk);
        // R1: quiet while in reset
        chk("R1 enable in reset", chan_enable, 0);
        chk("R1 fault in reset", fault, 0);
        chk("R1 stim in reset", stim_out, 0);
        wheel_in = 1'b1;
        #1 chk("R1 fwd in reset", wheel_fwd, 0);
        rst = 1'b0;
    endtask

    // Runs the WIN test-phase samples; pokes the handshake if asked (R4).
    task automatic shield_phase(input bit poke);
        int rises = 0, highs = 0, shape_bad = 0, leak = 0;
        logic prev = 1'b0;
        for (int i = 1; i <= WIN; i++) begin
            @(negedge clk);
            if (i == 1) chk("R1 first cycle after reset", chan_enable | fault | stim_out, 0);
            if (stim_out && !prev) rises++;
            if (stim_out) highs++;
            // R2: expected level from sample index
            if (stim_out != logic'((((i - 1) / HALF) % 2) == 1)) shape_bad++;
            if (chan_enable || fault || wheel_fwd) leak++;
            prev = stim_out;
            wheel_in = ~wheel_in;
            test_done = poke && (i == WIN / 2 || i == WIN / 2 + 1 || i == WIN - 1);
            test_pass = poke && (i == WIN / 2 || i == WIN - 1);
        end
        test_done = 1'b0; test_pass = 1'b0;
        chk("R2 tone shape mismatches", shape_bad, 0);
        chk("R2 high cycles (50% duty)", highs, WIN / 2);
        chk("R3 rising edges in window", rises, NP);
        chk("R4/R8 shielded during test", leak, 0);
    endtask

    initial begin
        // ---- Scenario 1: pass, with handshake noise during test ----
        do_reset();
        shield_phase(1'b1);
        @(negedge clk);
        chk("R3 stim low after window", stim_out, 0);
        chk("R4 still shielded after window", chan_enable, 0);
        chk("R4 no fault after window", fault, 0);
        test_done = 1'b1; test_pass = 1'b1;
        @(negedge clk);
        test_done = 1'b0; test_pass = 1'b0;
        chk("R5 enable after pass", chan_enable, 1);
        chk("R10 no fault on pass", fault, 0);
        for (int p = 0; p < 4; p++) begin
            wheel_in = p[0];
            #1 chk("R5 fwd follows wheel", wheel_fwd, p[0]);
            @(negedge clk);
        end
        test_done = 1'b1; test_pass = 1'b0;
        @(negedge clk);
        test_done = 1'b0;
        @(negedge clk);
        chk("R9 run ignores fail verdict", {chan_enable, fault}, 2);
        chk("R10 stim low in run", stim_out, 0);

        // ---- Scenario 2: fail verdict mid-wait ----
        do_reset();
        shield_phase(1'b0);
        repeat (7) @(negedge clk);
        test_done = 1'b1; test_pass = 1'b0;
        @(negedge clk);
        test_done = 1'b0;
        chk("R6 fault after fail", fault, 1);
        chk("R6 enable stays low", chan_enable, 0);
        test_done = 1'b1; test_pass = 1'b1;
        @(negedge clk);
        test_done = 1'b0; test_pass = 1'b0;
        for (int p = 0; p < 4; p++) begin
            wheel_in = p[0];
            #1 chk("R8 fwd blocked in fault", wheel_fwd, 0);
            @(negedge clk);
        end
        chk("R9 fault ignores pass verdict", {chan_enable, fault}, 1);
        chk("R10 stim low in fault", stim_out, 0);

        // ---- Scenario 3: timeout length ----
        do_reset();
        shield_phase(1'b0);
        begin
            int waited = 0;
            for (int k = 0; k < TO + 5; k++) begin
                @(negedge clk);
                if (fault) break;
                waited++;
            end
            chk("R7 waiting cycles before timeout", waited, TO);
            chk("R7 fault after timeout", fault, 1);
            chk("R7 enable low after timeout", chan_enable, 0);
        end

        // ---- Scenario 4: verdict in last waiting cycle beats timeout ----
        do_reset();
        shield_phase(1'b0);
        repeat (TO) @(negedge clk);
        chk("R7 no fault before deadline", fault, 0);
        test_done = 1'b1; test_pass = 1'b1;
        @(negedge clk);
        test_done = 1'b0; test_pass = 1'b0;
        chk("R7 verdict priority enable", chan_enable, 1);
        chk("R7 verdict priority no fault", fault, 0);

        // ---- Scenario 5: reset from run re-shields ----
        do_reset();
        shield_phase(1'b0);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule